// File: doc/BRIEF.md
# Multithreaded fetch PC sequencer

This block holds one fetch program counter per hardware thread of a small in-order pipeline. Each cycle, the threads that want to fetch raise a request bit. The block grants one eligible thread in round-robin order. It returns that thread's current PC as the fetch address and tags the fetch with the thread's 16-bit sequence number. The PC then advances by one 4-byte instruction and the sequence number increments.

A thread with an unknown next PC cannot fetch. Its request is answered with a stall bit instead of an address. A thread loses its known PC in two ways: a return instruction that has no stack prediction blocks its stage, or a faulting instruction squashes it. The PC is rewritten by three events: a squash from a later stage, a trap redirect, or a thread activation. The later stages report control instructions to the block. From these reports it raises either a block toward the reporting stage or a redirect request for predicted-taken branches. After a squash that is not a fault, it pulses an unblock toward the stage the thread had blocked.

Top module: `fetch_pc_sequencer`

## Requirements
- R1: After reset every thread is inactive. No grant, block, redirect or unblock is raised, and a request from any thread gives only its stall bit.
- R2: A granted fetch presents the thread's PC on fetch_addr and its sequence number on fetch_seq in the same cycle. Afterwards the PC is 4 higher and the sequence number 1 higher, with the sequence number wrapping from 0xFFFF to 0.
- R3: A request from a thread that is inactive or whose PC is not valid sets that thread's fetch_stall bit and is never granted.
- R4: Among eligible requesting threads one is granted per cycle. The grant goes to the first eligible thread after the last granted one, in ascending index order with wrap-around.
- R5: A reported control instruction that is a return and not predicted taken gives blk_valid, blk_tid and blk_stage in the next cycle for one cycle, clears that thread's PC-valid flag and records the stage.
- R6: A reported control instruction that is predicted taken gives redir_valid, redir_tid, redir_stage and redir_seq in the next cycle for one cycle. A report with ctl_is_ctrl low raises neither block nor redirect.
- R7: A squash with its fault flag set clears the thread's PC-valid flag. The PC is left alone, and fetch stays stalled until a trap redirect or an activation.
- R8: A squash from a control instruction loads the PC with its target. If the following delay-slot instruction is present (dslot valid) and its PC equals the target, the PC becomes target + 4 instead.
- R9: A squash from a non-control instruction loads the PC with that instruction's PC + 4.
- R10: A squash without a fault sets PC-valid. In the next cycle it raises the thread's bit of unblk_valid, and unblk_stage for that thread shows the stage recorded by the last block.
- R11: Squash ports are taken in order, lowest index first. A squash for a thread that already took a squash in the same cycle is ignored when the taken squash's sequence number is less than or equal to the new one. Otherwise the new one replaces it. Squashes for different threads, or squashes in different cycles, never interact.
- R12: A trap redirect loads the thread's PC with trap_pc and sets PC-valid.
- R13: Activation makes a thread eligible for fetch, with PC act_pc and PC-valid set. Deactivation returns every field of the thread to its reset value: inactive, PC 0, sequence number 0, last squash number all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | NT | Fetch request, one bit per thread |
| fetch_gnt | output | NT | One-hot grant of the served thread |
| fetch_stall | output | NT | Request refused: thread inactive or PC unknown |
| fetch_valid | output | 1 | A fetch is granted this cycle |
| fetch_tid | output | TID_W | Granted thread |
| fetch_addr | output | PC_W | Fetch address of the granted thread |
| fetch_seq | output | SEQ_W | Sequence number of the fetched instruction |
| ctl_valid | input | 1 | Control-instruction report valid |
| ctl_tid | input | TID_W | Thread of the report |
| ctl_stage | input | STG_W | Stage sending the report |
| ctl_seq | input | SEQ_W | Sequence number of the reported instruction |
| ctl_is_ctrl | input | 1 | Reported instruction is a control instruction |
| ctl_is_ret | input | 1 | Reported instruction is a return |
| ctl_pred_taken | input | 1 | Predictor marked it taken |
| blk_valid | output | 1 | Block pulse toward a stage |
| blk_tid | output | TID_W | Thread being blocked |
| blk_stage | output | STG_W | Stage to block |
| redir_valid | output | 1 | Redirect request for a predicted-taken branch |
| redir_tid | output | TID_W | Thread of the redirect |
| redir_stage | output | STG_W | Stage the redirect starts from |
| redir_seq | output | SEQ_W | Sequence number of the branch |
| sq_valid | input | NSQ | Squash valid per port |
| sq_tid | input | NSQ*TID_W | Squash thread per port |
| sq_seq | input | NSQ*SEQ_W | Squash sequence number per port |
| sq_fault | input | NSQ | Squash caused by a fault |
| sq_is_ctrl | input | NSQ | Squashing instruction is a control instruction |
| sq_pc | input | NSQ*PC_W | PC of the squashing instruction |
| sq_target | input | NSQ*PC_W | Predicted target of the squashing instruction |
| sq_dslot_valid | input | NSQ | Following delay-slot instruction is present |
| sq_dslot_pc | input | NSQ*PC_W | PC of that delay-slot instruction |
| trap_valid | input | 1 | Trap redirect valid |
| trap_tid | input | TID_W | Thread of the trap redirect |
| trap_pc | input | PC_W | Architectural PC to resume at |
| act_valid | input | 1 | Thread activation strobe |
| act_tid | input | TID_W | Thread to activate |
| act_pc | input | PC_W | Start PC of the activated thread |
| deact_valid | input | 1 | Thread deactivation strobe |
| deact_tid | input | TID_W | Thread to deactivate |
| unblk_valid | output | NT | Unblock pulse per thread |
| unblk_stage | output | NT*STG_W | Recorded blocking stage per thread |

## Verification
The PC update on squash is exercised from a table of squash patterns. The patterns cover a non-control squash, a control squash with no delay slot, with a delay slot at the target, with a delay slot elsewhere, with a matching PC but the delay slot marked absent, and a fault. Together they separate target from PC + 4, the delay-slot skip from the plain target, and a kept PC from a rewritten one. Fetch is exercised with a single requester, to check address and sequence increments including the 16-bit wrap, and with all threads requesting, to show the round-robin order and the stall of an inactive thread. Pairs of same-cycle squashes are given in younger-then-older, older-then-younger and equal order, and also for two different threads, which tells which squash sets the PC.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int PC_W       = 32;
    localparam int SEQ_W      = 16;
    localparam int STG_W      = 3;
    localparam int CYC_W      = 16;
    localparam int INST_BYTES = 4;

    typedef struct packed {
        logic              active;
        logic              pcv;
        logic [PC_W-1:0]   pc;
        logic [SEQ_W-1:0]  seq;
        logic [STG_W-1:0]  blk_stage;
        logic [SEQ_W-1:0]  sq_seq;
        logic [CYC_W-1:0]  sq_cyc;
    } thr_t;

    function automatic thr_t thr_init();
        thr_t t;
        t        = '0;
        t.sq_seq = '1;
        return t;
    endfunction

endpackage

// File: rtl/fpc_rr_arb.sv
module fpc_rr_arb #(
    parameter  int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  elig,
    input  logic [IW-1:0] last,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);

    int cand;

    always_comb begin
        gnt  = '0;
        idx  = '0;
        any  = 1'b0;
        cand = 0;
        for (int i = 1; i <= N; i++) begin
            cand = (int'(last) + i) % N;
            if (!any && elig[cand]) begin
                any       = 1'b1;
                idx       = IW'(cand);
                gnt[cand] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpc_redirect.sv
module fpc_redirect
    import fpc_pkg::*;
(
    input  logic            is_ctrl,
    input  logic [PC_W-1:0] inst_pc,
    input  logic [PC_W-1:0] target,
    input  logic            dslot_valid,
    input  logic [PC_W-1:0] dslot_pc,
    output logic [PC_W-1:0] new_pc
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

    always_comb begin
        if (is_ctrl) begin
            if (dslot_valid && (dslot_pc == target)) new_pc = target + STEP;
            else                                     new_pc = target;
        end else begin
            new_pc = inst_pc + STEP;
        end
    end

endmodule

// File: rtl/fetch_pc_sequencer.sv
module fetch_pc_sequencer
    import fpc_pkg::*;
#(
    parameter  int NT    = 4,
    parameter  int NSQ   = 2,
    localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NT-1:0]          fetch_req,
    output logic [NT-1:0]          fetch_gnt,
    output logic [NT-1:0]          fetch_stall,
    output logic                   fetch_valid,
    output logic [TID_W-1:0]       fetch_tid,
    output logic [PC_W-1:0]        fetch_addr,
    output logic [SEQ_W-1:0]       fetch_seq,
    input  logic                   ctl_valid,
    input  logic [TID_W-1:0]       ctl_tid,
    input  logic [STG_W-1:0]       ctl_stage,
    input  logic [SEQ_W-1:0]       ctl_seq,
    input  logic                   ctl_is_ctrl,
    input  logic                   ctl_is_ret,
    input  logic                   ctl_pred_taken,
    output logic                   blk_valid,
    output logic [TID_W-1:0]       blk_tid,
    output logic [STG_W-1:0]       blk_stage,
    output logic                   redir_valid,
    output logic [TID_W-1:0]       redir_tid,
    output logic [STG_W-1:0]       redir_stage,
    output logic [SEQ_W-1:0]       redir_seq,
    input  logic [NSQ-1:0]         sq_valid,
    input  logic [NSQ*TID_W-1:0]   sq_tid,
    input  logic [NSQ*SEQ_W-1:0]   sq_seq,
    input  logic [NSQ-1:0]         sq_fault,
    input  logic [NSQ-1:0]         sq_is_ctrl,
    input  logic [NSQ*PC_W-1:0]    sq_pc,
    input  logic [NSQ*PC_W-1:0]    sq_target,
    input  logic [NSQ-1:0]         sq_dslot_valid,
    input  logic [NSQ*PC_W-1:0]    sq_dslot_pc,
    input  logic                   trap_valid,
    input  logic [TID_W-1:0]       trap_tid,
    input  logic [PC_W-1:0]        trap_pc,
    input  logic                   act_valid,
    input  logic [TID_W-1:0]       act_tid,
    input  logic [PC_W-1:0]        act_pc,
    input  logic                   deact_valid,
    input  logic [TID_W-1:0]       deact_tid,
    output logic [NT-1:0]          unblk_valid,
    output logic [NT*STG_W-1:0]    unblk_stage
);

    localparam logic [PC_W-1:0]  STEP    = PC_W'(INST_BYTES);
    localparam logic [CYC_W-1:0] CYC_MAX = '1;

    typedef struct packed {
        logic              blk_v;
        logic [TID_W-1:0]  blk_tid;
        logic [STG_W-1:0]  blk_stage;
        logic              rd_v;
        logic [TID_W-1:0]  rd_tid;
        logic [STG_W-1:0]  rd_stage;
        logic [SEQ_W-1:0]  rd_seq;
        logic [NT-1:0]     unblk;
        logic [TID_W-1:0]  rr;
        logic [CYC_W-1:0]  cyc;
    } misc_t;

    thr_t  thr_d [NT];
    thr_t  thr_q [NT];
    misc_t m_d, m_q;

    logic [NT-1:0]    elig;
    logic [NT-1:0]    gnt;
    logic [TID_W-1:0] gidx;
    logic             gany;
    logic [PC_W-1:0]  rd_pc [NSQ];

    // eligibility and stall per thread
    always_comb begin
        for (int t = 0; t < NT; t++) begin
            elig[t]        = fetch_req[t] & thr_q[t].active & thr_q[t].pcv;
            fetch_stall[t] = fetch_req[t] & ~(thr_q[t].active & thr_q[t].pcv);
        end
    end

    fpc_rr_arb #(.N(NT)) u_arb (
        .elig (elig),
        .last (m_q.rr),
        .gnt  (gnt),
        .idx  (gidx),
        .any  (gany)
    );

    // per-port redirect target
    for (genvar p = 0; p < NSQ; p++) begin : g_redir
        fpc_redirect u_redir (
            .is_ctrl     (sq_is_ctrl[p]),
            .inst_pc     (sq_pc[p*PC_W +: PC_W]),
            .target      (sq_target[p*PC_W +: PC_W]),
            .dslot_valid (sq_dslot_valid[p]),
            .dslot_pc    (sq_dslot_pc[p*PC_W +: PC_W]),
            .new_pc      (rd_pc[p])
        );
    end

    assign fetch_gnt   = gnt;
    assign fetch_valid = gany;
    assign fetch_tid   = gidx;
    assign fetch_addr  = thr_q[gidx].pc;
    assign fetch_seq   = thr_q[gidx].seq;

    logic [TID_W-1:0] st;
    logic [SEQ_W-1:0] sseq;

    // next-state computation; later events override earlier ones
    always_comb begin
        thr_d     = thr_q;
        m_d       = m_q;
        m_d.blk_v = 1'b0;
        m_d.rd_v  = 1'b0;
        m_d.unblk = '0;
        m_d.cyc   = (m_q.cyc == CYC_MAX) ? CYC_W'(1) : m_q.cyc + CYC_W'(1);
        st        = '0;
        sseq      = '0;

        if (gany) begin
            thr_d[gidx].pc  = thr_q[gidx].pc + STEP;
            thr_d[gidx].seq = thr_q[gidx].seq + SEQ_W'(1);
            m_d.rr          = gidx;
        end

        if (ctl_valid && ctl_is_ctrl) begin
            if (ctl_is_ret && !ctl_pred_taken) begin
                m_d.blk_v                = 1'b1;
                m_d.blk_tid              = ctl_tid;
                m_d.blk_stage            = ctl_stage;
                thr_d[ctl_tid].pcv       = 1'b0;
                thr_d[ctl_tid].blk_stage = ctl_stage;
            end else if (ctl_pred_taken) begin
                m_d.rd_v     = 1'b1;
                m_d.rd_tid   = ctl_tid;
                m_d.rd_stage = ctl_stage;
                m_d.rd_seq   = ctl_seq;
            end
        end

        for (int p = 0; p < NSQ; p++) begin
            st   = sq_tid[p*TID_W +: TID_W];
            sseq = sq_seq[p*SEQ_W +: SEQ_W];
            if (sq_valid[p] &&
                !(thr_d[st].sq_cyc == m_q.cyc && thr_d[st].sq_seq <= sseq)) begin
                thr_d[st].sq_seq = sseq;
                thr_d[st].sq_cyc = m_q.cyc;
                if (sq_fault[p]) begin
                    thr_d[st].pcv = 1'b0;
                    m_d.unblk[st] = 1'b0;
                end else begin
                    thr_d[st].pc  = rd_pc[p];
                    thr_d[st].pcv = 1'b1;
                    m_d.unblk[st] = 1'b1;
                end
            end
        end

        if (trap_valid) begin
            thr_d[trap_tid].pc  = trap_pc;
            thr_d[trap_tid].pcv = 1'b1;
        end

        if (act_valid) begin
            thr_d[act_tid].active = 1'b1;
            thr_d[act_tid].pc     = act_pc;
            thr_d[act_tid].pcv    = 1'b1;
        end

        if (deact_valid) begin
            thr_d[deact_tid]     = thr_init();
            m_d.unblk[deact_tid] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) thr_q[t] <= thr_init();
            m_q     <= '0;
            m_q.cyc <= CYC_W'(1);
        end else begin
            for (int t = 0; t < NT; t++) thr_q[t] <= thr_d[t];
            m_q <= m_d;
        end
    end

    assign blk_valid   = m_q.blk_v;
    assign blk_tid     = m_q.blk_tid;
    assign blk_stage   = m_q.blk_stage;
    assign redir_valid = m_q.rd_v;
    assign redir_tid   = m_q.rd_tid;
    assign redir_stage = m_q.rd_stage;
    assign redir_seq   = m_q.rd_seq;
    assign unblk_valid = m_q.unblk;

    for (genvar t = 0; t < NT; t++) begin : g_ustg
        assign unblk_stage[t*STG_W +: STG_W] = thr_q[t].blk_stage;
    end

    // ---------------- assertions ----------------
    logic other_evt;
    assign other_evt = ctl_valid | (|sq_valid) | trap_valid | act_valid | deact_valid;

    p_gnt_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fetch_gnt));

    p_stall_no_gnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stall & fetch_gnt) == '0);

    p_fetch_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !other_evt) |=>
            (thr_q[$past(fetch_tid)].pc == $past(fetch_addr) + STEP) &&
            (thr_q[$past(fetch_tid)].seq == $past(fetch_seq) + SEQ_W'(1)));

    p_block_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_is_ctrl && ctl_is_ret && !ctl_pred_taken &&
         !(|sq_valid) && !trap_valid && !act_valid && !deact_valid) |=>
            (blk_valid && !thr_q[$past(ctl_tid)].pcv));

    for (genvar t = 0; t < NT; t++) begin : g_chk
        p_unblk_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
            unblk_valid[t] |-> thr_q[t].pcv);
    end

endmodule

// File: tb/fetch_pc_sequencer_bench.sv
module fetch_pc_sequencer_bench;

    localparam int NT = 4, NSQ = 2, TW = 2, PW = 32, SW = 16, GW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NT-1:0] fetch_req, fetch_gnt, fetch_stall, unblk_valid;
    logic fetch_valid; logic [TW-1:0] fetch_tid; logic [PW-1:0] fetch_addr; logic [SW-1:0] fetch_seq;
    logic ctl_valid, ctl_is_ctrl, ctl_is_ret, ctl_pred_taken;
    logic [TW-1:0] ctl_tid; logic [GW-1:0] ctl_stage; logic [SW-1:0] ctl_seq;
    logic blk_valid, redir_valid; logic [TW-1:0] blk_tid, redir_tid;
    logic [GW-1:0] blk_stage, redir_stage; logic [SW-1:0] redir_seq;
    logic [NSQ-1:0] sq_valid, sq_fault, sq_is_ctrl, sq_dslot_valid;
    logic [NSQ*TW-1:0] sq_tid; logic [NSQ*SW-1:0] sq_seq;
    logic [NSQ*PW-1:0] sq_pc, sq_target, sq_dslot_pc;
    logic trap_valid, act_valid, deact_valid;
    logic [TW-1:0] trap_tid, act_tid, deact_tid;
    logic [PW-1:0] trap_pc, act_pc;
    logic [NT*GW-1:0] unblk_stage;

    int n_cmp = 0, n_bad = 0;

    always #2 clk = ~clk;

    fetch_pc_sequencer #(.NT(NT), .NSQ(NSQ)) u_fetch_pc_sequencer (.*);

    typedef struct packed {
        logic ctl; logic flt; logic [31:0] pc; logic [31:0] tgt;
        logic dsv; logic [31:0] dspc; logic ev; logic [31:0] ea;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 32'h2000, 32'h0,    1'b0, 32'h0,    1'b1, 32'h2004}, // R9
        '{1'b1, 1'b0, 32'h2000, 32'h3000, 1'b0, 32'h0,    1'b1, 32'h3000}, // R8
        '{1'b1, 1'b0, 32'h2000, 32'h3000, 1'b1, 32'h3000, 1'b1, 32'h3004}, // R8
        '{1'b1, 1'b0, 32'h2000, 32'h3000, 1'b1, 32'h2ffc, 1'b1, 32'h3000}, // R8
        '{1'b1, 1'b0, 32'h2000, 32'h3000, 1'b0, 32'h3000, 1'b1, 32'h3000}, // R8
        '{1'b0, 1'b1, 32'h2000, 32'h3000, 1'b0, 32'h0,    1'b0, 32'h0}     // R7
    };

    task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", r, a, e);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        fetch_req = '0; ctl_valid = 0; ctl_is_ctrl = 0; ctl_is_ret = 0; ctl_pred_taken = 0;
        ctl_tid = '0; ctl_stage = '0; ctl_seq = '0;
        sq_valid = '0; sq_fault = '0; sq_is_ctrl = '0; sq_dslot_valid = '0;
        sq_tid = '0; sq_seq = '0; sq_pc = '0; sq_target = '0; sq_dslot_pc = '0;
        trap_valid = 0; trap_tid = '0; trap_pc = '0;
        act_valid = 0; act_tid = '0; act_pc = '0; deact_valid = 0; deact_tid = '0;
    endtask

    task automatic activate(input int t, input logic [31:0] pc);
        act_valid = 1; act_tid = TW'(t); act_pc = pc; tick(); act_valid = 0;
    endtask

    task automatic deactivate(input int t);
        deact_valid = 1; deact_tid = TW'(t); tick(); deact_valid = 0;
    endtask

    task automatic squash(input int p, input int t, input int seq, input logic flt,
                          input logic ctl, input logic [31:0] pc, input logic [31:0] tgt,
                          input logic dsv, input logic [31:0] dspc);
        sq_valid[p] = 1; sq_tid[p*TW +: TW] = TW'(t); sq_seq[p*SW +: SW] = SW'(seq);
        sq_fault[p] = flt; sq_is_ctrl[p] = ctl; sq_pc[p*PW +: PW] = pc;
        sq_target[p*PW +: PW] = tgt; sq_dslot_valid[p] = dsv; sq_dslot_pc[p*PW +: PW] = dspc;
    endtask

    // request one thread, check the comb fetch outputs, clock, release
    task automatic fetch_chk(input string r, input int t, input logic ev, input logic [31:0] ea);
        fetch_req = '0; fetch_req[t] = 1'b1; #1;
        chk(r, {63'd0, fetch_valid}, {63'd0, ev});
        if (ev) chk(r, fetch_addr, ea);
        else    chk(r, {63'd0, fetch_stall[t]}, 64'd1);
        tick(); fetch_req = '0;
    endtask

    initial begin
        #(4 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        fetch_req = '1; #1;
        chk("R1 valid", {63'd0, fetch_valid}, 64'd0);
        chk("R1 stall", {60'd0, fetch_stall}, 64'hf);
        chk("R1 blk", {62'd0, blk_valid, redir_valid}, 64'd0);
        chk("R1 unblk", {60'd0, unblk_valid}, 64'd0);
        tick(); idle();

        // R2: sequential fetch on thread 1
        activate(1, 32'h100);
        fetch_req = 4'b0010;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk("R2 addr", fetch_addr, 64'h100 + 4 * k);
            chk("R2 seq", {48'd0, fetch_seq}, k);
            chk("R2 tid", {62'd0, fetch_tid}, 64'd1);
            tick();
        end
        idle();

        // R4: round robin, last granted = 1; thread 3 inactive stalls (R3)
        activate(0, 32'h1000);
        activate(2, 32'h2000);
        fetch_req = 4'b1111;
        begin
            int exp_t [4] = '{2, 0, 1, 2};
            logic [31:0] exp_a [4] = '{32'h2000, 32'h1000, 32'h110, 32'h2004};
            for (int k = 0; k < 4; k++) begin
                #1;
                chk("R4 tid", {62'd0, fetch_tid}, exp_t[k]);
                chk("R4 addr", fetch_addr, exp_a[k]);
                chk("R3 stall", {60'd0, fetch_stall}, 64'h8);
                tick();
            end
        end
        idle();

        // R7 R8 R9 R10: squash table on thread 0
        for (int v = 0; v < 6; v++) begin
            activate(0, 32'h1000);
            squash(0, 0, 100 + v, VECS[v].flt, VECS[v].ctl, VECS[v].pc, VECS[v].tgt,
                   VECS[v].dsv, VECS[v].dspc);
            tick(); idle();
            chk("R10 unblk pulse", {63'd0, unblk_valid[0]}, {63'd0, VECS[v].ev});
            fetch_chk(VECS[v].flt ? "R7 fault" : (VECS[v].ctl ? "R8 ctrl" : "R9 noctrl"),
                      0, VECS[v].ev, VECS[v].ea);
        end

        // R5: unpredicted return blocks thread 2 at stage 5
        ctl_valid = 1; ctl_tid = 2; ctl_stage = 5; ctl_is_ctrl = 1; ctl_is_ret = 1;
        tick(); idle();
        chk("R5 blk", {59'd0, blk_valid, blk_tid, blk_stage}, {59'd0, 1'b1, 2'd2, 3'd5});
        fetch_chk("R5 stall", 2, 1'b0, 32'h0);
        chk("R5 pulse", {63'd0, blk_valid}, 64'd0);

        // R10: non-fault squash unblocks the recorded stage
        squash(0, 2, 10, 0, 0, 32'h4000, 32'h0, 0, 32'h0);
        tick(); idle();
        chk("R10 unblk", {60'd0, unblk_valid}, 64'h4);
        chk("R10 stage", {61'd0, unblk_stage[6 +: 3]}, 64'd5);
        fetch_chk("R10 fetch", 2, 1'b1, 32'h4004);

        // R6: predicted-taken redirect, then non-control report
        ctl_valid = 1; ctl_tid = 0; ctl_stage = 3; ctl_seq = 16'h55; ctl_is_ctrl = 1; ctl_pred_taken = 1;
        tick(); idle();
        chk("R6 redir", {43'd0, redir_valid, redir_tid, redir_stage, redir_seq},
            {43'd0, 1'b1, 2'd0, 3'd3, 16'h55});
        chk("R6 noblk", {63'd0, blk_valid}, 64'd0);
        ctl_valid = 1; ctl_tid = 0; ctl_is_ctrl = 0; ctl_is_ret = 1; ctl_pred_taken = 1;
        tick(); idle();
        chk("R6 nonctrl", {62'd0, blk_valid, redir_valid}, 64'd0);

        // R11: same-cycle squash arbitration on thread 2
        squash(0, 2, 20, 0, 0, 32'h5000, 0, 0, 0); squash(1, 2, 30, 0, 0, 32'h6000, 0, 0, 0);
        tick(); idle();
        fetch_chk("R11 younger ignored", 2, 1'b1, 32'h5004);
        squash(0, 2, 40, 0, 0, 32'h7000, 0, 0, 0); squash(1, 2, 35, 0, 0, 32'h8000, 0, 0, 0);
        tick(); idle();
        fetch_chk("R11 older wins", 2, 1'b1, 32'h8004);
        squash(0, 2, 50, 0, 0, 32'h9000, 0, 0, 0); squash(1, 2, 50, 0, 0, 32'hA000, 0, 0, 0);
        tick(); idle();
        fetch_chk("R11 equal ignored", 2, 1'b1, 32'h9004);
        squash(0, 0, 60, 0, 0, 32'hB000, 0, 0, 0); squash(1, 2, 70, 0, 0, 32'hC000, 0, 0, 0);
        tick(); idle();
        fetch_chk("R11 two threads t0", 0, 1'b1, 32'hB004);
        fetch_chk("R11 two threads t2", 2, 1'b1, 32'hC004);

        // R7 then R12: fault holds stall until trap
        squash(0, 0, 80, 1, 0, 32'h0, 0, 0, 0);
        tick(); idle();
        fetch_chk("R7 stall", 0, 1'b0, 32'h0);
        trap_valid = 1; trap_tid = 0; trap_pc = 32'hD000;
        tick(); idle();
        fetch_chk("R12 trap", 0, 1'b1, 32'hD000);

        // R13: deactivate, then reactivate with fresh sequence number
        deactivate(2);
        fetch_chk("R13 deact stall", 2, 1'b0, 32'h0);
        activate(2, 32'hE000);
        fetch_req = 4'b0100; #1;
        chk("R13 react addr", fetch_addr, 64'hE000);
        chk("R13 react seq", {48'd0, fetch_seq}, 64'd0);
        tick(); idle();

        // R2: 16-bit sequence wrap on thread 1
        deactivate(1);
        activate(1, 32'h100);
        fetch_req = 4'b0010;
        for (int k = 0; k < 65536; k++) tick();
        #1;
        chk("R2 wrap seq", {48'd0, fetch_seq}, 64'd0);
        chk("R2 wrap addr", fetch_addr, 64'h40100);
        idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule